// File: doc/BRIEF.md
# Memory and IO Request Completer

This block is the target end of a request path. Requests that have already been routed to the local device arrive one at a time. Each one has a header: an operation kind, a doubleword address, a length in doublewords, a first and a last byte-enable nibble, and a tag. Write requests follow the header with one payload doubleword per beat. The block serves each request against a local byte-addressable memory or against a small bank of IO registers. It derives the starting byte address and the byte count of the access from the header fields, and it sends back a completion packet whenever the operation calls for one.

Memory writes are posted, so nothing comes back for them. Memory reads and IO reads are answered with a completion that carries data. An IO write is answered with a completion that carries no data. An IO request whose length is not one doubleword performs no access and is answered with unsupported-request status.

A completion leaves the block as a run of beats. The header fields are held steady on parallel ports for every beat of the run, and a data doubleword is presented on each beat. While a completion is being sent, the block accepts no new request.

Top module: `cplr_top`

## Requirements
- R1: While reset is asserted, and after it, `cpl_valid` is 0 and `in_ready` is 1. Every IO register reads as zero after reset.
- R2: A memory read (kind 2'b00) of N doublewords produces a completion with data. That completion has `cpl_fmt_type` 8'h4A, status 3'b000 and `cpl_len_dw` = N. It has N beats, which return consecutive locations starting at the request address, and `cpl_last` is 1 only on the final beat.
- R3: A memory write (kind 2'b01) stores its payload and produces no completion. Beat 0 is gated by the first byte enables, the final beat of a request longer than one doubleword is gated by the last byte enables, and the beats in between write all four bytes. Bit i of an enable nibble controls byte lane i, which is data bits 8i+7 to 8i.
- R4: The memory read byte count is computed as follows. For a one-doubleword request, it is the span from the lowest to the highest enabled byte of the first enables, or 1 if those enables are zero. For a longer request, it is 4·N minus the lanes below the lowest enabled first-enable bit, minus the lanes above the highest enabled last-enable bit.
- R5: The memory read `cpl_lower_addr` is formed from two parts. Its bits 6..2 are address bits 6..2 of the request, and its bits 1..0 give the lane of the lowest enabled first-enable bit, or 0 when the first enables are zero.
- R6: Every completion returns the tag of the request it answers.
- R7: An IO read (kind 2'b10) of one doubleword returns the addressed IO register in a single completion beat with data (8'h4A), with byte count 4 and lower address 0.
- R8: An IO write (kind 2'b11) of one doubleword stores the payload lanes selected by the first enables. It is answered by one completion beat without data: 8'h0A, `cpl_len_dw` 0, status 3'b000, byte count 4, lower address 0.
- R9: An IO read or IO write whose length is not one doubleword is answered by a single 8'h0A beat with status 3'b001. It changes no IO register, and the payload of such a write is consumed and discarded.
- R10: Memory locations are indexed by the doubleword address modulo the memory depth, and a burst that passes the top location continues at location 0. IO registers are indexed by the low address bits modulo the register count.
- R11: The first completion beat appears in the cycle after the header (for a read) or the last payload beat (for an IO write) is accepted. `in_ready` stays low on every completion beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header or payload beat present |
| in_ready | output | 1 | Block accepts the current beat |
| in_kind | input | 2 | 00 memory read, 01 memory write, 10 IO read, 11 IO write |
| in_dw_addr | input | MIW (6) | Doubleword address of the first doubleword |
| in_len | input | LEN_W (4) | Length in doublewords, at least 1 |
| in_first_be | input | 4 | Byte enables of the first doubleword |
| in_last_be | input | 4 | Byte enables of the last doubleword |
| in_tag | input | 8 | Requester tag |
| in_data | input | 32 | Payload doubleword of a write beat |
| cpl_valid | output | 1 | Completion beat present |
| cpl_last | output | 1 | Final beat of the completion |
| cpl_fmt_type | output | 8 | 8'h4A with data, 8'h0A without data |
| cpl_status | output | 3 | 000 success, 001 unsupported request |
| cpl_tag | output | 8 | Echoed tag |
| cpl_byte_count | output | 12 | Bytes covered by the access |
| cpl_lower_addr | output | 7 | Low byte address of the first enabled byte |
| cpl_len_dw | output | LEN_W (4) | Data length of the completion in doublewords |
| cpl_data | output | 32 | Completion data doubleword |

## Verification
A table of memory reads sweeps the byte-enable shapes that the byte count and lower address rules tell apart: full, sparse, zero, high-lane-only and partial at both ends. It also covers lengths of 1, 2, 3, 4 and 15 and addresses that end on the top of a 128-byte window. Write-then-read pairs separate full writes from edge-masked writes, and a burst across the top memory location shows the index wrap. IO traffic compares a legal write with a masked write and with writes and reads of illegal length, and each is followed by a read that shows whether the register moved. An IO read at an aliased address shows the register wrap.

// File: rtl/cplr_pkg.sv
package cplr_pkg;

    typedef enum logic [1:0] {
        K_MRD  = 2'b00,
        K_MWR  = 2'b01,
        K_IORD = 2'b10,
        K_IOWR = 2'b11
    } req_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WR,
        S_RD,
        S_CPL
    } cplr_state_e;

    localparam logic [7:0] FT_CPL  = 8'h0A;
    localparam logic [7:0] FT_CPLD = 8'h4A;
    localparam logic [2:0] ST_OK   = 3'b000;
    localparam logic [2:0] ST_UR   = 3'b001;

    localparam int BC_W = 12;
    localparam int LA_W = 7;

    typedef struct packed {
        logic            is_io;
        logic            bad_len;
        logic [BC_W-1:0] bytes;
        logic [LA_W-1:0] low_addr;
    } req_info_t;

    // lane of the lowest enabled byte (0 when none)
    function automatic logic [1:0] lead_lane(input logic [3:0] be);
        if (be[0])      return 2'd0;
        else if (be[1]) return 2'd1;
        else if (be[2]) return 2'd2;
        else if (be[3]) return 2'd3;
        else            return 2'd0;
    endfunction

    // lane of the highest enabled byte (0 when none)
    function automatic logic [1:0] top_lane(input logic [3:0] be);
        if (be[3])      return 2'd3;
        else if (be[2]) return 2'd2;
        else if (be[1]) return 2'd1;
        else            return 2'd0;
    endfunction

    function automatic logic [BC_W-1:0] calc_bytes(input logic [BC_W-1:0] len_dw,
                                                   input logic [3:0] fbe,
                                                   input logic [3:0] lbe);
        logic [BC_W-1:0] lo, hi;
        lo = BC_W'(lead_lane(fbe));
        if (len_dw == BC_W'(1)) begin
            hi = BC_W'(top_lane(fbe));
            if (fbe == 4'h0) return BC_W'(1);
            return hi - lo + BC_W'(1);
        end
        hi = BC_W'(top_lane(lbe));
        return (len_dw << 2) - lo - (BC_W'(3) - hi);
    endfunction

endpackage

// File: rtl/cplr_req_decode.sv
module cplr_req_decode
    import cplr_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  req_kind_e        kind,
    input  logic [4:0]       dw_low,
    input  logic [LEN_W-1:0] len,
    input  logic [3:0]       first_be,
    input  logic [3:0]       last_be,
    output req_info_t        info
);
    logic io_req;

    assign io_req = (kind == K_IORD) || (kind == K_IOWR);

    always_comb begin
        info.is_io   = io_req;
        info.bad_len = io_req && (len != LEN_W'(1));
        if (io_req) begin
            info.bytes    = BC_W'(4);
            info.low_addr = '0;
        end else begin
            info.bytes    = calc_bytes(BC_W'(len), first_be, last_be);
            info.low_addr = {dw_low, lead_lane(first_be)};
        end
    end
endmodule

// File: rtl/cplr_space.sv
module cplr_space #(
    parameter int MEM_DW = 64,
    parameter int IO_DW  = 8,
    localparam int MIW   = $clog2(MEM_DW),
    localparam int IIW   = $clog2(IO_DW)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic           sel_io,
    input  logic [MIW-1:0] idx,
    input  logic [3:0]     be,
    input  logic [31:0]    wdata,
    output logic [31:0]    rdata
);
    logic [IIW-1:0] io_idx;
    assign io_idx = idx[IIW-1:0];

    // one storage slice per byte lane
    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] mem_b [MEM_DW];
        logic [7:0] io_b  [IO_DW];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < IO_DW; i++) io_b[i] <= '0;
            end else if (we && be[g] && sel_io) begin
                io_b[io_idx] <= wdata[8*g +: 8];
            end
        end

        always_ff @(posedge clk) begin
            if (we && be[g] && !sel_io) mem_b[idx] <= wdata[8*g +: 8];
        end

        assign rdata[8*g +: 8] = sel_io ? io_b[io_idx] : mem_b[idx];
    end
endmodule

// File: rtl/cplr_top.sv
module cplr_top
    import cplr_pkg::*;
#(
    parameter int MEM_DW = 64,
    parameter int IO_DW  = 8,
    parameter int LEN_W  = 4,
    localparam int MIW   = $clog2(MEM_DW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_kind,
    input  logic [MIW-1:0]   in_dw_addr,
    input  logic [LEN_W-1:0] in_len,
    input  logic [3:0]       in_first_be,
    input  logic [3:0]       in_last_be,
    input  logic [7:0]       in_tag,
    input  logic [31:0]      in_data,
    output logic             cpl_valid,
    output logic             cpl_last,
    output logic [7:0]       cpl_fmt_type,
    output logic [2:0]       cpl_status,
    output logic [7:0]       cpl_tag,
    output logic [11:0]      cpl_byte_count,
    output logic [6:0]       cpl_lower_addr,
    output logic [LEN_W-1:0] cpl_len_dw,
    output logic [31:0]      cpl_data
);
    cplr_state_e      state;
    req_kind_e        kind_in, r_kind;
    req_info_t        info;
    logic [MIW-1:0]   r_addr;
    logic [LEN_W-1:0] r_len, beat;
    logic [3:0]       r_fbe, r_lbe;
    logic [7:0]       r_tag;
    logic [BC_W-1:0]  r_bytes;
    logic [LA_W-1:0]  r_low;
    logic             r_io, r_bad;
    logic             last_beat, take;
    logic             st_we;
    logic [MIW-1:0]   st_idx;
    logic [3:0]       st_be;
    logic [31:0]      st_rdata;

    assign kind_in = req_kind_e'(in_kind);

    cplr_req_decode #(.LEN_W(LEN_W)) u_dec (
        .kind     (kind_in),
        .dw_low   (in_dw_addr[4:0]),
        .len      (in_len),
        .first_be (in_first_be),
        .last_be  (in_last_be),
        .info     (info)
    );

    assign last_beat = (beat == r_len - LEN_W'(1));
    assign in_ready  = (state == S_IDLE) || (state == S_WR);
    assign take      = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            beat    <= '0;
            r_kind  <= K_MRD;
            r_addr  <= '0;
            r_len   <= '0;
            r_fbe   <= '0;
            r_lbe   <= '0;
            r_tag   <= '0;
            r_bytes <= '0;
            r_low   <= '0;
            r_io    <= 1'b0;
            r_bad   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (in_valid) begin
                    r_kind  <= kind_in;
                    r_addr  <= in_dw_addr;
                    r_len   <= in_len;
                    r_fbe   <= in_first_be;
                    r_lbe   <= in_last_be;
                    r_tag   <= in_tag;
                    r_bytes <= info.bytes;
                    r_low   <= info.low_addr;
                    r_io    <= info.is_io;
                    r_bad   <= info.bad_len;
                    beat    <= '0;
                    unique case (kind_in)
                        K_MRD:  state <= S_RD;
                        K_MWR:  state <= S_WR;
                        K_IORD: state <= info.bad_len ? S_CPL : S_RD;
                        K_IOWR: state <= S_WR;
                    endcase
                end
                S_WR: if (in_valid) begin
                    if (last_beat) begin
                        beat  <= '0;
                        state <= (r_kind == K_IOWR) ? S_CPL : S_IDLE;
                    end else begin
                        beat <= beat + LEN_W'(1);
                    end
                end
                S_RD: begin
                    if (last_beat) begin
                        beat  <= '0;
                        state <= S_IDLE;
                    end else begin
                        beat <= beat + LEN_W'(1);
                    end
                end
                S_CPL: state <= S_IDLE;
            endcase
        end
    end

    // storage access: one shared index for the current beat
    assign st_idx = r_addr + MIW'(beat);
    assign st_we  = (state == S_WR) && take && !r_bad;
    always_comb begin
        if (beat == '0)  st_be = r_fbe;
        else if (last_beat) st_be = r_lbe;
        else             st_be = 4'hF;
    end

    cplr_space #(.MEM_DW(MEM_DW), .IO_DW(IO_DW)) u_space (
        .clk    (clk),
        .rst    (rst),
        .we     (st_we),
        .sel_io (r_io),
        .idx    (st_idx),
        .be     (st_be),
        .wdata  (in_data),
        .rdata  (st_rdata)
    );

    // completion outputs
    assign cpl_valid      = (state == S_RD) || (state == S_CPL);
    assign cpl_last       = (state == S_CPL) || ((state == S_RD) && last_beat);
    assign cpl_fmt_type   = (state == S_RD) ? FT_CPLD : FT_CPL;
    assign cpl_status     = ((state == S_CPL) && r_bad) ? ST_UR : ST_OK;
    assign cpl_tag        = r_tag;
    assign cpl_byte_count = r_bytes;
    assign cpl_lower_addr = r_low;
    assign cpl_len_dw     = (state == S_RD) ? r_len : '0;
    assign cpl_data       = (state == S_RD) ? st_rdata : 32'h0;

    // posted writes never answer
    assert_mwr_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (take && (state == S_IDLE) && (in_kind == 2'b01)) |=> !cpl_valid);

    // a completion run is unbroken and its header holds
    assert_run_contiguous_R2: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !cpl_last) |=> (cpl_valid && $stable(cpl_tag) && $stable(cpl_byte_count)));

    // unsupported status only on a single beat without data
    assert_ur_nodata_R9: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && (cpl_status == ST_UR)) |-> ((cpl_fmt_type == FT_CPL) && cpl_last));

    // no request accepted while answering
    assert_busy_while_cpl_R11: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> !in_ready);

    // a completion never reports an empty access
    assert_bytes_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> (cpl_byte_count != 12'd0));

    // a storage write happens only while payload is being taken
    assert_write_in_payload_R8: assert property (@(posedge clk) disable iff (rst)
        st_we |-> (in_valid && !cpl_valid));
endmodule

// File: tb/sim_cplr_top.sv
module sim_cplr_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready;
    logic [1:0]  in_kind;
    logic [5:0]  in_dw_addr;
    logic [3:0]  in_len, in_first_be, in_last_be;
    logic [7:0]  in_tag;
    logic [31:0] in_data;
    logic        cpl_valid, cpl_last;
    logic [7:0]  cpl_fmt_type, cpl_tag;
    logic [2:0]  cpl_status;
    logic [11:0] cpl_byte_count;
    logic [6:0]  cpl_lower_addr;
    logic [3:0]  cpl_len_dw;
    logic [31:0] cpl_data;

    always #4 clk = ~clk;

    cplr_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_dw_addr(in_dw_addr), .in_len(in_len),
        .in_first_be(in_first_be), .in_last_be(in_last_be), .in_tag(in_tag),
        .in_data(in_data), .cpl_valid(cpl_valid), .cpl_last(cpl_last),
        .cpl_fmt_type(cpl_fmt_type), .cpl_status(cpl_status), .cpl_tag(cpl_tag),
        .cpl_byte_count(cpl_byte_count), .cpl_lower_addr(cpl_lower_addr),
        .cpl_len_dw(cpl_len_dw), .cpl_data(cpl_data)
    );

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    logic [31:0] pay [16];
    logic [31:0] got [16];
    int          nbeats;
    logic [7:0]  g_ft, g_tag;
    logic [2:0]  g_st;
    logic [11:0] g_bc;
    logic [6:0]  g_la;
    logic [3:0]  g_len;

    // {byte addr 8, len 4, fbe 4, lbe 4, tag 8, bytes 12, lower addr 7}
    localparam logic [46:0] VEC [8] = '{
        {8'h10, 4'd1,  4'hF, 4'h0, 8'h01, 12'd4,  7'h10},
        {8'h14, 4'd1,  4'h6, 4'h0, 8'h02, 12'd2,  7'h15},
        {8'h20, 4'd1,  4'h0, 4'h0, 8'h03, 12'd1,  7'h20},
        {8'h24, 4'd2,  4'hC, 4'h3, 8'h04, 12'd4,  7'h26},
        {8'h40, 4'd4,  4'hF, 4'hF, 8'h05, 12'd16, 7'h40},
        {8'h7C, 4'd3,  4'h8, 4'h1, 8'h06, 12'd6,  7'h7F},
        {8'h0C, 4'd1,  4'h8, 4'h0, 8'h07, 12'd1,  7'h0F},
        {8'h30, 4'd15, 4'hE, 4'h7, 8'h08, 12'd58, 7'h31}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drives header then payload; returns at the negedge after the last accept
    task automatic issue(input logic [1:0] k, input logic [7:0] baddr, input logic [3:0] len,
                         input logic [3:0] fbe, input logic [3:0] lbe, input logic [7:0] tag,
                         input int npay);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_dw_addr = baddr[7:2]; in_len = len;
        in_first_be = fbe; in_last_be = lbe; in_tag = tag; in_data = 32'h0;
        @(posedge clk);
        for (int i = 0; i < npay; i++) begin
            @(negedge clk);
            in_data = pay[i];
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic collect(input string req);
        nbeats = 0;
        chk({req, " R11 first beat timing"}, {31'h0, cpl_valid}, 32'h1);
        if (!cpl_valid) return;
        g_ft = cpl_fmt_type; g_st = cpl_status; g_tag = cpl_tag;
        g_bc = cpl_byte_count; g_la = cpl_lower_addr; g_len = cpl_len_dw;
        for (int i = 0; i < 16; i++) begin
            got[i] = cpl_data;
            nbeats++;
            if (i == 0) chk({req, " R11 in_ready low"}, {31'h0, in_ready}, 32'h0);
            if (cpl_last) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_kind = 2'b00; in_dw_addr = '0; in_len = 4'd1;
        in_first_be = 4'h0; in_last_be = 4'h0; in_tag = '0; in_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 cpl_valid in reset", {31'h0, cpl_valid}, 32'h0);
        chk("R1 in_ready in reset", {31'h0, in_ready}, 32'h1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 in_ready after reset", {31'h0, in_ready}, 32'h1);
        issue(2'b10, 8'h04, 4'd1, 4'hF, 4'h0, 8'h90, 0);
        collect("R1 io reset value");
        chk("R1 io reads zero", got[0], 32'h0);

        // table of memory reads: byte count, lower address, tag, length
        for (int v = 0; v < 8; v++) begin
            issue(2'b00, VEC[v][46:39], VEC[v][38:35], VEC[v][34:31], VEC[v][30:27],
                  VEC[v][26:19], 0);
            collect("R2 table read");
            chk("R2 fmt_type", {24'h0, g_ft}, 32'h4A);
            chk("R2 status", {29'h0, g_st}, 32'h0);
            chk("R2 beats", nbeats, {28'h0, VEC[v][38:35]});
            chk("R2 len field", {28'h0, g_len}, {28'h0, VEC[v][38:35]});
            chk("R4 byte count", {20'h0, g_bc}, {20'h0, VEC[v][18:7]});
            chk("R5 lower addr", {25'h0, g_la}, {25'h0, VEC[v][6:0]});
            chk("R6 tag", {24'h0, g_tag}, {24'h0, VEC[v][26:19]});
        end

        // full memory write, no completion, read back
        pay[0] = 32'hA0A1A2A3; pay[1] = 32'hB0B1B2B3; pay[2] = 32'hC0C1C2C3;
        issue(2'b01, 8'h80, 4'd3, 4'hF, 4'hF, 8'h11, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R3 no completion for memory write", {31'h0, cpl_valid}, 32'h0);
            @(negedge clk);
        end
        issue(2'b00, 8'h80, 4'd3, 4'hF, 4'hF, 8'h12, 0);
        collect("R2 readback");
        chk("R2 data0", got[0], 32'hA0A1A2A3);
        chk("R2 data1", got[1], 32'hB0B1B2B3);
        chk("R2 data2", got[2], 32'hC0C1C2C3);
        chk("R6 tag readback", {24'h0, g_tag}, 32'h12);

        // edge-masked memory write
        pay[0] = 32'h11111111; pay[1] = 32'h22222222;
        issue(2'b01, 8'hA0, 4'd2, 4'hF, 4'hF, 8'h13, 2);
        pay[0] = 32'hAAAAAAAA; pay[1] = 32'hBBBBBBBB;
        issue(2'b01, 8'hA0, 4'd2, 4'hC, 4'h3, 8'h14, 2);
        chk("R3 no completion masked write", {31'h0, cpl_valid}, 32'h0);
        issue(2'b00, 8'hA0, 4'd2, 4'hF, 4'hF, 8'h15, 0);
        collect("R3 masked readback");
        chk("R3 first enables", got[0], 32'hAAAA1111);
        chk("R3 last enables", got[1], 32'h2222BBBB);

        // burst across the top location
        pay[0] = 32'hCAFEF00D; pay[1] = 32'h0BADBEEF;
        issue(2'b01, 8'hFC, 4'd2, 4'hF, 4'hF, 8'h16, 2);
        issue(2'b00, 8'h00, 4'd1, 4'hF, 4'h0, 8'h17, 0);
        collect("R10 wrap low");
        chk("R10 wrapped write", got[0], 32'h0BADBEEF);
        issue(2'b00, 8'hFC, 4'd2, 4'hF, 4'hF, 8'h18, 0);
        collect("R10 wrap read");
        chk("R10 top location", got[0], 32'hCAFEF00D);
        chk("R10 wrapped read", got[1], 32'h0BADBEEF);

        // IO write then read
        pay[0] = 32'h12345678;
        issue(2'b11, 8'h08, 4'd1, 4'hF, 4'h0, 8'h21, 1);
        collect("R8 io write cpl");
        chk("R8 fmt_type", {24'h0, g_ft}, 32'h0A);
        chk("R8 status", {29'h0, g_st}, 32'h0);
        chk("R8 len", {28'h0, g_len}, 32'h0);
        chk("R8 bytes", {20'h0, g_bc}, 32'd4);
        chk("R8 lower addr", {25'h0, g_la}, 32'h0);
        chk("R6 io tag", {24'h0, g_tag}, 32'h21);
        chk("R8 single beat", nbeats, 1);
        issue(2'b10, 8'h08, 4'd1, 4'hF, 4'h0, 8'h22, 0);
        collect("R7 io read");
        chk("R7 fmt_type", {24'h0, g_ft}, 32'h4A);
        chk("R7 data", got[0], 32'h12345678);
        chk("R7 bytes", {20'h0, g_bc}, 32'd4);
        chk("R7 lower addr", {25'h0, g_la}, 32'h0);
        chk("R7 single beat", nbeats, 1);

        // IO masked write
        pay[0] = 32'hFFFFFF9A;
        issue(2'b11, 8'h08, 4'd1, 4'h1, 4'h0, 8'h23, 1);
        collect("R8 masked io write");
        issue(2'b10, 8'h08, 4'd1, 4'hF, 4'h0, 8'h24, 0);
        collect("R8 masked io read");
        chk("R8 masked io data", got[0], 32'h1234569A);

        // IO requests of illegal length
        pay[0] = 32'h0; pay[1] = 32'h0;
        issue(2'b11, 8'h08, 4'd2, 4'hF, 4'hF, 8'h25, 2);
        collect("R9 io write len2");
        chk("R9 status", {29'h0, g_st}, 32'h1);
        chk("R9 fmt_type", {24'h0, g_ft}, 32'h0A);
        chk("R6 ur tag", {24'h0, g_tag}, 32'h25);
        issue(2'b10, 8'h08, 4'd2, 4'hF, 4'hF, 8'h26, 0);
        collect("R9 io read len2");
        chk("R9 read status", {29'h0, g_st}, 32'h1);
        chk("R9 read no data", {24'h0, g_ft}, 32'h0A);
        chk("R9 read single beat", nbeats, 1);
        issue(2'b10, 8'h08, 4'd1, 4'hF, 4'h0, 8'h27, 0);
        collect("R9 io untouched");
        chk("R9 register unchanged", got[0], 32'h1234569A);

        // IO register aliasing
        issue(2'b10, 8'h28, 4'd1, 4'hF, 4'h0, 8'h28, 0);
        collect("R10 io alias");
        chk("R10 io alias data", got[0], 32'h1234569A);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule